// File: doc/BRIEF.md
# Thermal Threshold Interrupt Unit

This block watches an 8-bit temperature code produced by an on-chip sensor and turns threshold crossings into interrupts. Software programs four rising levels and four falling levels through a small word-addressed register bus. Each time the sensor presents a new sample, the block compares it with the previous accepted sample. A status bit records every level that was crossed upward or downward. A single interrupt line combines the status bits that software has enabled. A separate hardware trip output latches when the code reaches the highest rising level, provided trip is enabled.

The sensor input is a valid-only stream: `smp_valid` marks a cycle that carries a code on `smp_code`. The block accepts every sample in the cycle it arrives. It never applies back-pressure, so the stream carries no ready signal, and a producer may present a sample on any cycle. An emulation register lets software substitute a code of its own for the sensor code, so the threshold logic can be exercised without heating the die. The bus is a plain single-cycle port. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr` while `bus_sel` is high, and zero otherwise.

Register map (word addresses): 0 control, 1 rising levels, 2 falling levels, 3 interrupt enables, 4 status (read only), 5 clear (write only, reads 0), 6 emulation, 7 current code (read only).

Top module: `thermal_thresh_irq`

## Requirements
- R1: After reset, every register is 0, the status word is 0, and `irq`, `trip` and `cur_code` are 0.
- R2: Level i (i = 0..3) of the rising thresholds sits in bits [8i+7:8i] of address 1. Level i of the falling thresholds sits in the same byte of address 2. Both registers read back as written.
- R3: On an accepted sample, status bit i (address 4, bit i) sets when the previous accepted code was below rising level i and the new code is at or above it. The bit is visible from the clock edge that takes the sample. The first sample after reset, or after core enable is turned back on, only sets the reference and raises no status.
- R4: On an accepted sample, status bit 16+i sets when the previous accepted code was above falling level i and the new code is at or below it.
- R5: Address 3 holds the rise enables in bits [3:0] and the fall enables in the same pattern shifted to bits [19:16]. Status bits set whether or not they are enabled. `irq` is high exactly when an enabled status bit is set and core enable is on.
- R6: Writing address 5 clears exactly the status bits written as 1, so writing back the value read from address 4 clears all of them. If a new event and a clear hit the same bit at the same edge, the bit stays set.
- R7: Control bit 0 is core enable. While it is 0, samples are ignored: status and `cur_code` stay unchanged, and `irq` is held low.
- R8: Control bit 1 is trip enable. `trip` rises one edge after an accepted sample whose code is at or above rising level 3 while trip enable is set. Once set, it stays high until reset, even if the control bits are cleared.
- R9: Address 6 holds the emulation enable in bit 0 and an emulated code in bits [15:8]. While enabled, every accepted sample uses the emulated code in place of `smp_code`.
- R10: `cur_code`, and address 7 in bits [7:0], give the last accepted code after any emulation substitution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sensor sample valid (never back-pressured) |
| smp_code | input | 8 | Sensor temperature code |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Combined enabled-status interrupt |
| trip | output | 1 | Latched hardware trip |
| cur_code | output | 8 | Last accepted code |

## Verification
On every cycle, the assertions check the following:
- `irq` stays low while core enable is off, and never rises without a status bit set.
- Status gains new bits only after a cycle holding an accepted sample.
- Status holds still when neither a sample nor a clear arrives.
- `cur_code` moves only after a valid sample.
- `trip` never falls once it has risen.

The directed scenarios show what a property cannot easily express:
- the byte-lane packing of the thresholds;
- which levels a particular jump crosses, in each direction;
- the reference-only first sample after re-enable;
- set-over-clear priority;
- emulation substitution;
- the exact level at which trip fires.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int N_LVL    = 4;
  localparam int CODE_W   = 8;
  localparam int FALL_OFS = 16;
  localparam int EMU_OFS  = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_RISE = 3'd1,
    A_FALL = 3'd2,
    A_IEN  = 3'd3,
    A_STAT = 3'd4,
    A_CLR  = 3'd5,
    A_EMUL = 3'd6,
    A_CODE = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/thr_regfile.sv
module thr_regfile
  import thr_pkg::*;
#(
  parameter int NLVL = N_LVL,
  parameter int CW   = CODE_W,
  parameter int FOFS = FALL_OFS,
  parameter int EOFS = EMU_OFS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] stat_word,
  input  logic [CW-1:0]     code_now,
  output logic [DATA_W-1:0] rdata,
  output logic              core_en,
  output logic              trip_en,
  output logic [NLVL*CW-1:0] rise_thr,
  output logic [NLVL*CW-1:0] fall_thr,
  output logic [NLVL-1:0]   rise_en,
  output logic [NLVL-1:0]   fall_en,
  output logic              emu_en,
  output logic [CW-1:0]     emu_code,
  output logic              clr_we,
  output logic [NLVL-1:0]   clr_rise,
  output logic [NLVL-1:0]   clr_fall
);
  logic we;
  logic [DATA_W-1:0] ien_word;
  logic [DATA_W-1:0] mux;

  assign we = sel & wr;
  assign clr_we   = we && (addr == A_CLR);
  assign clr_rise = clr_we ? wdata[NLVL-1:0]   : '0;
  assign clr_fall = clr_we ? wdata[FOFS+:NLVL] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_en  <= 1'b0;
      trip_en  <= 1'b0;
      rise_thr <= '0;
      fall_thr <= '0;
      rise_en  <= '0;
      fall_en  <= '0;
      emu_en   <= 1'b0;
      emu_code <= '0;
    end else if (we) begin
      case (addr)
        A_CTRL: begin
          core_en <= wdata[0];
          trip_en <= wdata[1];
        end
        A_RISE: rise_thr <= wdata[NLVL*CW-1:0];
        A_FALL: fall_thr <= wdata[NLVL*CW-1:0];
        A_IEN: begin
          rise_en <= wdata[NLVL-1:0];
          fall_en <= wdata[FOFS+:NLVL];
        end
        A_EMUL: begin
          emu_en   <= wdata[0];
          emu_code <= wdata[EOFS+:CW];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ien_word = '0;
    ien_word[NLVL-1:0]   = rise_en;
    ien_word[FOFS+:NLVL] = fall_en;
  end

  always_comb begin
    mux = '0;
    case (addr)
      A_CTRL: mux[1:0] = {trip_en, core_en};
      A_RISE: mux[NLVL*CW-1:0] = rise_thr;
      A_FALL: mux[NLVL*CW-1:0] = fall_thr;
      A_IEN:  mux = ien_word;
      A_STAT: mux = stat_word;
      A_EMUL: begin
        mux[0]        = emu_en;
        mux[EOFS+:CW] = emu_code;
      end
      A_CODE: mux[CW-1:0] = code_now;
      default: mux = '0;
    endcase
  end

  assign rdata = (sel && !wr) ? mux : '0;
endmodule

// File: rtl/thr_level_det.sv
module thr_level_det #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] prev_code,
  input  logic [CW-1:0] new_code,
  input  logic [CW-1:0] up_lvl,
  input  logic [CW-1:0] dn_lvl,
  output logic          up_hit,
  output logic          dn_hit
);
  assign up_hit = (prev_code < up_lvl) && (new_code >= up_lvl);
  assign dn_hit = (prev_code > dn_lvl) && (new_code <= dn_lvl);
endmodule

// File: rtl/thr_status.sv
module thr_status #(
  parameter int NLVL = 4,
  parameter int CW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            core_en,
  input  logic            trip_en,
  input  logic            strobe,
  input  logic [CW-1:0]   eff_code,
  input  logic [NLVL-1:0] up_hit,
  input  logic [NLVL-1:0] dn_hit,
  input  logic            top_hit,
  input  logic [NLVL-1:0] clr_rise,
  input  logic [NLVL-1:0] clr_fall,
  output logic [NLVL-1:0] rise_st,
  output logic [NLVL-1:0] fall_st,
  output logic [CW-1:0]   last_code,
  output logic            trip_q
);
  logic accept;
  logic ref_ok;
  logic [NLVL-1:0] rise_set, fall_set;

  assign accept   = strobe & core_en;
  assign rise_set = (accept && ref_ok) ? up_hit : '0;
  assign fall_set = (accept && ref_ok) ? dn_hit : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_st   <= '0;
      fall_st   <= '0;
      last_code <= '0;
      ref_ok    <= 1'b0;
      trip_q    <= 1'b0;
    end else begin
      rise_st <= (rise_st & ~clr_rise) | rise_set;
      fall_st <= (fall_st & ~clr_fall) | fall_set;
      if (!core_en) begin
        ref_ok <= 1'b0;
      end else if (strobe) begin
        last_code <= eff_code;
        ref_ok    <= 1'b1;
      end
      if (accept && trip_en && top_hit) trip_q <= 1'b1;
    end
  end
endmodule

// File: rtl/thermal_thresh_irq.sv
module thermal_thresh_irq
  import thr_pkg::*;
#(
  parameter int NLVL = N_LVL,
  parameter int CW   = CODE_W,
  parameter int FOFS = FALL_OFS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CW-1:0]     smp_code,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              trip,
  output logic [CW-1:0]     cur_code
);
  localparam int TOP_LSB = (NLVL - 1) * CW;

  logic core_en, trip_en, emu_en, clr_we;
  logic [NLVL*CW-1:0] rise_thr, fall_thr;
  logic [NLVL-1:0] rise_en, fall_en, clr_rise, clr_fall;
  logic [NLVL-1:0] up_hit, dn_hit, rise_st, fall_st;
  logic [CW-1:0] emu_code, eff_code;
  logic [DATA_W-1:0] stat_word;
  logic top_hit;

  assign eff_code = emu_en ? emu_code : smp_code;
  assign top_hit  = eff_code >= rise_thr[TOP_LSB+:CW];

  always_comb begin
    stat_word = '0;
    stat_word[NLVL-1:0]   = rise_st;
    stat_word[FOFS+:NLVL] = fall_st;
  end

  thr_regfile #(.NLVL(NLVL), .CW(CW), .FOFS(FOFS), .EOFS(EMU_OFS)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .stat_word(stat_word), .code_now(cur_code),
    .rdata(bus_rdata), .core_en(core_en), .trip_en(trip_en),
    .rise_thr(rise_thr), .fall_thr(fall_thr), .rise_en(rise_en),
    .fall_en(fall_en), .emu_en(emu_en), .emu_code(emu_code),
    .clr_we(clr_we), .clr_rise(clr_rise), .clr_fall(clr_fall)
  );

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    thr_level_det #(.CW(CW)) u_det (
      .prev_code(cur_code), .new_code(eff_code),
      .up_lvl(rise_thr[g*CW+:CW]), .dn_lvl(fall_thr[g*CW+:CW]),
      .up_hit(up_hit[g]), .dn_hit(dn_hit[g])
    );
  end

  thr_status #(.NLVL(NLVL), .CW(CW)) u_stat (
    .clk(clk), .rst_n(rst_n), .core_en(core_en), .trip_en(trip_en),
    .strobe(smp_valid), .eff_code(eff_code), .up_hit(up_hit),
    .dn_hit(dn_hit), .top_hit(top_hit), .clr_rise(clr_rise),
    .clr_fall(clr_fall), .rise_st(rise_st), .fall_st(fall_st),
    .last_code(cur_code), .trip_q(trip)
  );

  assign irq = core_en & ((|(rise_st & rise_en)) | (|(fall_st & fall_en)));
endmodule

// File: rtl/thr_checker.sv
module thr_checker #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strobe,
  input logic          core_en,
  input logic          clr_we,
  input logic          irq,
  input logic          trip,
  input logic [31:0]   status,
  input logic [CW-1:0] cur_code
);
  // R7
  irq_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |-> !irq);

  // R5
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != '0));

  // R3
  status_set_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe && core_en) |=> ((status & ~$past(status)) == '0));

  // R6
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !clr_we) |=> $stable(status));

  // R8
  trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> trip);

  // R10
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(cur_code));
endmodule

bind thermal_thresh_irq thr_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(smp_valid), .core_en(core_en),
  .clr_we(clr_we), .irq(irq), .trip(trip), .status(stat_word),
  .cur_code(cur_code)
);

// File: tb/test_thermal_thresh_irq.sv
module test_thermal_thresh_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [7:0]  smp_code = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, trip;
  logic [7:0]  cur_code;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  thermal_thresh_irq i_thermal_thresh_irq (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .trip(trip),
    .cur_code(cur_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic smp(input logic [7:0] c);
    @(negedge clk);
    smp_valid = 1'b1; smp_code = c;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 trip", {31'b0, trip}, 0);
    chk("R1 cur_code", {24'b0, cur_code}, 0);
    rd(3'd4, d); chk("R1 status", d, 0);
    rd(3'd1, d); chk("R1 rise reg", d, 0);
  endtask

  task automatic t_pack;
    logic [31:0] d;
    wr(3'd1, 32'h6050_4030);
    wr(3'd2, 32'h5848_3828);
    rd(3'd1, d); chk("R2 rise levels", d, 32'h6050_4030);
    rd(3'd2, d); chk("R2 fall levels", d, 32'h5848_3828);
  endtask

  task automatic t_rise;
    logic [31:0] d;
    wr(3'd0, 32'h1);
    smp(8'h20);
    rd(3'd4, d); chk("R3 reference sample", d, 0);
    smp(8'h45);
    rd(3'd4, d); chk("R3 rise l0 l1", d, 32'h3);
    chk("R5 irq disabled", {31'b0, irq}, 0);
    chk("R10 cur_code", {24'b0, cur_code}, 32'h45);
    rd(3'd7, d); chk("R10 code reg", d, 32'h45);
    wr(3'd3, 32'h1);
    chk("R5 irq rise en", {31'b0, irq}, 1);
    wr(3'd5, 32'h3);
    rd(3'd4, d); chk("R6 clear rise", d, 0);
    chk("R6 irq after clear", {31'b0, irq}, 0);
  endtask

  task automatic t_fall;
    logic [31:0] d;
    smp(8'h30);
    rd(3'd4, d); chk("R4 fall l1", d, 32'h0002_0000);
    wr(3'd3, 32'h0001_0001);
    chk("R5 fall bit not enabled", {31'b0, irq}, 0);
    wr(3'd3, 32'h0002_0000);
    chk("R5 fall en", {31'b0, irq}, 1);
    wr(3'd5, 32'h0);
    rd(3'd4, d); chk("R6 zero clear keeps", d, 32'h0002_0000);
    wr(3'd5, d);
    rd(3'd4, d); chk("R6 write-back clear", d, 0);
  endtask

  task automatic t_core_off;
    logic [31:0] d;
    smp(8'h50);
    rd(3'd4, d); chk("R3 rise l1 l2", d, 32'h6);
    wr(3'd3, 32'h2);
    chk("R5 irq", {31'b0, irq}, 1);
    wr(3'd0, 32'h0);
    chk("R7 irq masked", {31'b0, irq}, 0);
    smp(8'h10);
    chk("R7 code held", {24'b0, cur_code}, 32'h50);
    rd(3'd4, d); chk("R7 status held", d, 32'h6);
    wr(3'd0, 32'h1);
    chk("R7 irq back", {31'b0, irq}, 1);
    smp(8'h10);
    rd(3'd4, d); chk("R3 reference after enable", d, 32'h6);
    wr(3'd5, 32'h6);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    @(negedge clk);
    smp_valid = 1'b1; smp_code = 8'h35;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 32'h1;
    @(negedge clk);
    smp_valid = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    rd(3'd4, d); chk("R6 set beats clear", d, 32'h1);
    wr(3'd5, 32'h1);
  endtask

  task automatic t_emul;
    logic [31:0] d;
    wr(3'd6, 32'h0000_6201);
    rd(3'd6, d); chk("R9 emul reg", d, 32'h0000_6201);
    smp(8'h00);
    chk("R9 emulated code", {24'b0, cur_code}, 32'h62);
    rd(3'd4, d); chk("R9 emul rise", d, 32'hE);
    chk("R8 no trip when disabled", {31'b0, trip}, 0);
    wr(3'd5, 32'hE);
    wr(3'd6, 32'h0);
    smp(8'h20);
    rd(3'd4, d); chk("R4 all fall", d, 32'h000F_0000);
    wr(3'd5, d);
  endtask

  task automatic t_trip;
    wr(3'd0, 32'h3);
    smp(8'h5F);
    chk("R8 below top", {31'b0, trip}, 0);
    smp(8'h60);
    chk("R8 trip at top", {31'b0, trip}, 1);
    wr(3'd0, 32'h1);
    smp(8'h00);
    chk("R8 trip held", {31'b0, trip}, 1);
    wr(3'd0, 32'h0);
    chk("R8 trip held off", {31'b0, trip}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pack();
    t_rise();
    t_fall();
    t_core_off();
    t_set_wins();
    t_emul();
    t_trip();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule